// File: doc/BRIEF.md
# Shared Timer Clock-Enable Prescaler

This block generates the count-enable pulses for two timer/counters from one shared free-running prescaler. The prescaler is a 10-bit counter that advances on every I/O clock. Each timer has its own 3-bit clock-select field. That field picks one of five division taps, an edge of that timer's external pin, or no clock at all. The external pins pass through a two-flop synchronizer and an edge detector, so the timers only ever see clean single-cycle enables in the I/O clock domain.

An 8-bit control register holds three bits: a prescaler clear, a hold mode and a capture-input select. A write with only the clear bit set restarts the prescaler. The clear bit then drops on its own. When hold mode is set in the same write, the clear stays in force. The prescaler stays at zero and every tick output stays low, which lets software load both timers at leisure. A later write that turns hold mode off releases both timers in the same clock. The capture-select bit routes one of two capture inputs to the timer-1 capture output.

Top module: `tmr_prescale_top`

## Requirements
- R1: After reset the control register reads 0x00, every tick output is low, and `cap_out` follows `cap_a`.
- R2: A write with bit 0 = 1 and bit 7 = 0 holds the prescaler clear for exactly one cycle. In that cycle both tick outputs are low. Bit 0 then clears itself and reads back 0.
- R3: Clock-select code 0 gives no tick at all.
- R4: Clock-select codes 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 cycles. After a prescaler clear is released, the first tick comes in the N-th cycle after release, and the next one comes N cycles later.
- R5: Code 7 ticks on a rising edge and code 6 on a falling edge of the timer's own external pin. Each tick is one cycle long. It is high in the cycle that follows the second clock edge after the pin changes. The opposite edge gives no tick.
- R6: A write of bit 7 = 1 together with bit 0 = 1 holds the prescaler clear. While the clear is held, both tick outputs stay low for every code, the external edges included, and bit 0 reads back 1.
- R7: A write that clears bit 7 releases a held clear at that write's clock edge. Both timers then start from the same cycle: two timers that use the same code tick together.
- R8: Control bit 6 selects the capture source: 0 routes `cap_a` to `cap_out`, and 1 routes `cap_b`.
- R9: Control bits 5 to 1 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 7 hold mode, bit 6 capture select, bit 0 prescaler clear) |
| ctl_rdata | output | 8 | Control register read value |
| t0_sel | input | 3 | Timer 0 clock-select code |
| t1_sel | input | 3 | Timer 1 clock-select code |
| t0_pin | input | 1 | Timer 0 external clock pin, asynchronous |
| t1_pin | input | 1 | Timer 1 external clock pin, asynchronous |
| cap_a | input | 1 | Capture input A |
| cap_b | input | 1 | Capture input B |
| t0_tick | output | 1 | Timer 0 count enable |
| t1_tick | output | 1 | Timer 1 count enable |
| cap_out | output | 1 | Selected timer 1 capture input |

## Verification
The bench uses the default parameters: a 10-bit prescaler, five taps and a two-stage synchronizer. With a 10-bit prescaler the 1024 ratio is within a few thousand cycles, so the bench can measure every ratio's first-tick offset and period after a clear. With the two-stage synchronizer the external-edge latency comes out at a fixed, exact cycle, and the bench checks the tick in that cycle. The hold-and-release sequence is run with both timers on the same code, so the bench sees them start in the same cycle.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int PS_W        = 10;
  localparam int NUM_TAPS    = 5;
  localparam int SEL_W       = 3;
  localparam int SYNC_STAGES = 2;
  localparam int CTL_W       = 8;
  localparam int NUM_TMR     = 2;
  localparam int CLR_BIT     = 0;
  localparam int CAPSEL_BIT  = 6;
  localparam int HOLD_BIT    = 7;

  typedef enum logic [SEL_W-1:0] {
    CS_OFF      = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_sel_e;

  // log2 of the division ratio for tap index idx
  function automatic int tap_log2(input int idx);
    case (idx)
      0:       return 0;
      1:       return 3;
      2:       return 6;
      3:       return 8;
      default: return 10;
    endcase
  endfunction

  // true when the lg low bits of cnt are all ones
  function automatic logic tap_hit(input logic [PS_W-1:0] cnt, input int lg);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < PS_W; b++) begin
      if (b < lg && !cnt[b]) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/tps_ctrl.sv
module tps_ctrl
  import tps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] rdata,
  output logic             presc_clr,
  output logic             sync_hold,
  output logic             cap_sel
);
  logic hold_q, capsel_q, clr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      capsel_q <= 1'b0;
      clr_q    <= 1'b0;
    end else if (wr_en) begin
      hold_q   <= wdata[HOLD_BIT];
      capsel_q <= wdata[CAPSEL_BIT];
      clr_q    <= wdata[CLR_BIT];
    end else if (!hold_q) begin
      clr_q    <= 1'b0;
    end
  end

  always_comb begin
    rdata             = '0;
    rdata[HOLD_BIT]   = hold_q;
    rdata[CAPSEL_BIT] = capsel_q;
    rdata[CLR_BIT]    = clr_q & hold_q;
  end

  assign presc_clr = clr_q;
  assign sync_hold = hold_q;
  assign cap_sel   = capsel_q;
endmodule

// File: rtl/tps_prescaler.sv
module tps_prescaler
  import tps_pkg::*;
#(
  parameter int W  = PS_W,
  parameter int NT = NUM_TAPS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [W-1:0]  cnt,
  output logic [NT-1:0] tap_en
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NT; g++) begin : g_tap
    assign tap_en[g] = !clr && tap_hit(cnt_q, tap_log2(g));
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tps_edge_sync.sv
module tps_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tps_clk_mux.sv
module tps_clk_mux
  import tps_pkg::*;
#(
  parameter int NT = NUM_TAPS
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NT-1:0]    tap_en,
  input  logic             ext_rise,
  input  logic             ext_fall,
  input  logic             halt,
  output logic             tick
);
  always_comb begin
    tick = 1'b0;
    if (sel == CS_EXT_FALL)      tick = ext_fall;
    else if (sel == CS_EXT_RISE) tick = ext_rise;
    else begin
      for (int i = 0; i < NT; i++) begin
        if (int'(sel) == i + 1) tick = tap_en[i];
      end
    end
    if (halt) tick = 1'b0;
  end
endmodule

// File: rtl/tmr_prescale_top.sv
module tmr_prescale_top
  import tps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic [SEL_W-1:0] t0_sel,
  input  logic [SEL_W-1:0] t1_sel,
  input  logic             t0_pin,
  input  logic             t1_pin,
  input  logic             cap_a,
  input  logic             cap_b,
  output logic             t0_tick,
  output logic             t1_tick,
  output logic             cap_out
);
  logic                presc_clr;
  logic                sync_hold;
  logic                cap_sel;
  logic [PS_W-1:0]     presc_cnt;
  logic [NUM_TAPS-1:0] tap_en;
  logic [NUM_TMR-1:0]  ext_rise, ext_fall, ext_pin, tick_v;
  logic [SEL_W-1:0]    sel_v [NUM_TMR];

  assign ext_pin  = {t1_pin, t0_pin};
  assign sel_v[0] = t0_sel;
  assign sel_v[1] = t1_sel;

  tps_ctrl u_ctrl (
    .clk, .rst_n, .wr_en(ctl_wr), .wdata(ctl_wdata), .rdata(ctl_rdata),
    .presc_clr, .sync_hold, .cap_sel
  );

  tps_prescaler #(.W(PS_W), .NT(NUM_TAPS)) u_presc (
    .clk, .rst_n, .clr(presc_clr), .cnt(presc_cnt), .tap_en
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    tps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n, .pin(ext_pin[t]), .rise(ext_rise[t]), .fall(ext_fall[t])
    );
    tps_clk_mux #(.NT(NUM_TAPS)) u_mux (
      .sel(sel_v[t]), .tap_en, .ext_rise(ext_rise[t]), .ext_fall(ext_fall[t]),
      .halt(presc_clr), .tick(tick_v[t])
    );
  end

  assign t0_tick = tick_v[0];
  assign t1_tick = tick_v[1];
  assign cap_out = cap_sel ? cap_b : cap_a;
endmodule

// File: rtl/tps_checks.sv
module tps_checks
  import tps_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             presc_clr,
  input logic             sync_hold,
  input logic [PS_W-1:0]  presc_cnt,
  input logic [SEL_W-1:0] t0_sel,
  input logic [SEL_W-1:0] t1_sel,
  input logic             t0_tick,
  input logic             t1_tick,
  input logic [NUM_TMR-1:0] ext_rise,
  input logic [NUM_TMR-1:0] ext_fall
);
  a_r2_clear_self_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_clr && !sync_hold && !ctl_wr) |=> !presc_clr);

  a_r2_count_zero_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |=> presc_cnt == '0);

  a_r4_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
    !presc_clr |=> presc_cnt == $past(presc_cnt) + 1'b1);

  a_r6_clear_halts_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |-> (!t0_tick && !t1_tick));

  a_r6_held_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_clr && sync_hold && !ctl_wr) |=> (ctl_rdata[CLR_BIT] && presc_clr));

  a_r3_off_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_sel == CS_OFF) |-> !t0_tick);

  a_r5_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise[0] |=> !ext_rise[0]);

  a_r5_fall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fall[1] |=> !ext_fall[1]);

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[5:1] == '0);
endmodule

bind tmr_prescale_top tps_checks u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rdata(ctl_rdata),
  .presc_clr(presc_clr), .sync_hold(sync_hold), .presc_cnt(presc_cnt),
  .t0_sel(t0_sel), .t1_sel(t1_sel), .t0_tick(t0_tick), .t1_tick(t1_tick),
  .ext_rise(ext_rise), .ext_fall(ext_fall)
);

// File: tb/tmr_prescale_top_tb.sv
module tmr_prescale_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic [2:0] t0_sel = '0, t1_sel = '0;
  logic       t0_pin = 1'b0, t1_pin = 1'b0;
  logic       cap_a = 1'b0, cap_b = 1'b0;
  logic       t0_tick, t1_tick, cap_out;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tmr_prescale_top u_dut (
    .clk, .rst_n, .ctl_wr, .ctl_wdata, .ctl_rdata, .t0_sel, .t1_sel,
    .t0_pin, .t1_pin, .cap_a, .cap_b, .t0_tick, .t1_tick, .cap_out
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write ends on the negedge after the capturing edge
  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk(ctl_rdata == 8'h00, "R1 rdata", ctl_rdata, 0);
    cap_a = 1'b1; cap_b = 1'b0; #1;
    chk(cap_out == 1'b1, "R1 cap A", cap_out, 1);
    chk(t0_tick == 1'b0 && t1_tick == 1'b0, "R1 ticks", t0_tick, 0);
  endtask

  task automatic t_off();
    int n = 0;
    t0_sel = 3'd0; t1_sel = 3'd0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      n += t0_tick + t1_tick;
    end
    chk(n == 0, "R3 code0 ticks", n, 0);
  endtask

  task automatic t_ratio(input logic [2:0] code, input int ratio);
    int first = -1, second = -1;
    t0_sel = code; t1_sel = code;
    wr_ctl(8'h01);
    chk(!t0_tick && !t1_tick, "R2 halt during clear", t0_tick, 0);
    chk(ctl_rdata[0] == 1'b0, "R2 clear reads 0", ctl_rdata[0], 0);
    for (int i = 0; i < 2 * ratio + 2; i++) begin
      @(negedge clk);
      if (t0_tick) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
    end
    chk(first == ratio - 1, "R4 first tick", first, ratio - 1);
    chk(second == 2 * ratio - 1, "R4 period", second, 2 * ratio - 1);
  endtask

  task automatic t_hold_release();
    int n = 0, f0 = -1, f1 = -1;
    t0_sel = 3'd2; t1_sel = 3'd2;
    wr_ctl(8'h81);
    chk(ctl_rdata == 8'h81, "R6 held readback", ctl_rdata, 8'h81);
    t1_sel = 3'd1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      n += t0_tick + t1_tick;
    end
    chk(n == 0, "R6 ticks held", n, 0);
    t1_sel = 3'd2;
    wr_ctl(8'h00);
    for (int i = 0; i < 20; i++) begin
      if (i > 0) @(negedge clk);
      if (t0_tick && f0 < 0) f0 = i;
      if (t1_tick && f1 < 0) f1 = i;
    end
    chk(f0 == 7, "R7 t0 start", f0, 7);
    chk(f1 == f0, "R7 same cycle", f1, f0);
  endtask

  task automatic t_ext();
    t0_sel = 3'd7; t1_sel = 3'd6;
    t1_pin = 1'b1;
    repeat (5) @(negedge clk);
    t0_pin = 1'b1;
    @(negedge clk);
    chk(t0_tick == 1'b0, "R5 rise early", t0_tick, 0);
    @(negedge clk);
    chk(t0_tick == 1'b1, "R5 rise tick", t0_tick, 1);
    @(negedge clk);
    chk(t0_tick == 1'b0, "R5 rise one cycle", t0_tick, 0);
    t1_pin = 1'b0;
    @(negedge clk);
    chk(t1_tick == 1'b0, "R5 fall early", t1_tick, 0);
    @(negedge clk);
    chk(t1_tick == 1'b1, "R5 fall tick", t1_tick, 1);
    @(negedge clk);
    chk(t1_tick == 1'b0, "R5 fall one cycle", t1_tick, 0);
    t0_pin = 1'b0;
    begin
      int n = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        n += t0_tick;
      end
      chk(n == 0, "R5 opposite edge", n, 0);
    end
  endtask

  task automatic t_ext_held();
    int n = 0;
    t0_sel = 3'd7;
    wr_ctl(8'h81);
    t0_pin = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      n += t0_tick;
    end
    chk(n == 0, "R6 ext held", n, 0);
    wr_ctl(8'h00);
    t0_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_ctl_bits();
    wr_ctl(8'h7E);
    chk(ctl_rdata == 8'h40, "R9 reserved", ctl_rdata, 8'h40);
    cap_a = 1'b0; cap_b = 1'b1; #1;
    chk(cap_out == 1'b1, "R8 cap B", cap_out, 1);
    cap_b = 1'b0; #1;
    chk(cap_out == 1'b0, "R8 cap B low", cap_out, 0);
    wr_ctl(8'hFF);
    chk(ctl_rdata == 8'hC1, "R9 reserved held", ctl_rdata, 8'hC1);
    wr_ctl(8'h00);
    cap_a = 1'b1; #1;
    chk(cap_out == 1'b1, "R8 cap A", cap_out, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_off();
    t_ratio(3'd1, 1);
    t_ratio(3'd2, 8);
    t_ratio(3'd3, 64);
    t_ratio(3'd4, 256);
    t_ratio(3'd5, 1024);
    t_hold_release();
    t_ext();
    t_ext_held();
    t_ctl_bits();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule